// File: doc/BRIEF.md
# Dirty-Band Display Update Tracker

This block records which parts of a frame buffer have changed since the last screen refresh, at a granularity of one band of four display lines. A bus-side snoop reports writes to the indexed-colour plane, and a second snoop reports writes to the wide planes that hold direct colour and per-pixel control words. Each write marks its band dirty.

A refresh pass walks the visible bands from the top, one band per clock. Each run of neighbouring dirty bands becomes one update rectangle, given as a start line and a line count, always at the full configured width. After the pass, the block clears the dirty bits across the span from the first to the last dirty band it saw.

A palette change or a full invalidate is signalled on a single input that marks every band dirty. In true-colour mode, changes to the wide planes also count toward a band being dirty. In indexed mode those changes are ignored when the pass decides what to report.

Top module: `dirty_band_tracker`

## Requirements
- R1: A write on the indexed snoop at byte address A marks band A >> (STRIDE_LOG2+2) dirty, since one band is four lines at a 2^STRIDE_LOG2-byte stride. The next refresh pass reports that band. Addresses whose band number is NUM_BANDS or more are ignored.
- R2: During a pass, each maximal run of neighbouring dirty bands from band s up to band e produces exactly one rectangle with rect_y = 4*s and rect_h = 4*(e-s+1). The rectangle appears when the first clean band after the run is visited.
- R3: A run that is still open after the last visible band produces a rectangle at the end of the pass. Its height reaches 4 times the number of visible bands.
- R4: When a pass finishes, the dirty bits of every band from the lowest to the highest dirty band it found are cleared, in both the indexed and the wide tracking. Nothing is cleared if no band was dirty, and bands outside that span keep their state.
- R5: A write on the wide snoop at byte address A marks band A >> (STRIDE_LOG2+4) dirty, because each band spans four wide pages. This mark counts in a pass only when true_color was 1 at refresh_start; otherwise the pass reports nothing for it.
- R6: A cycle with mark_all high marks every band dirty, so the next pass reports one rectangle covering all visible bands.
- R7: Reset clears every dirty bit, returns the block to idle with busy low, and leaves rect_valid low.
- R8: A write to a band in the same cycle that the end-of-pass clear covers that band leaves the band dirty.
- R9: A pass visits ceil(vis_lines/4) bands, limited to NUM_BANDS, and every rectangle carries rect_w equal to the vis_width captured at refresh_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| true_color | input | 1 | Include wide-plane changes; sampled at refresh_start |
| vis_lines | input | LINE_W | Visible height in lines; sampled at refresh_start |
| vis_width | input | WIDTH_W | Visible width in pixels; sampled at refresh_start |
| wr8_en | input | 1 | Indexed-plane write snoop valid |
| wr8_addr | input | PIX_AW | Indexed-plane write byte address |
| wrw_en | input | 1 | Wide-plane write snoop valid |
| wrw_addr | input | PIX_AW+2 | Wide-plane write byte address |
| mark_all | input | 1 | Mark every band dirty |
| refresh_start | input | 1 | Start a refresh pass when idle |
| busy | output | 1 | A pass is in progress |
| rect_valid | output | 1 | One-cycle rectangle strobe |
| rect_y | output | LINE_W | First line of the rectangle |
| rect_h | output | LINE_W | Height of the rectangle in lines |
| rect_w | output | WIDTH_W | Width of the rectangle in pixels |

## Verification
The bench builds the block with NUM_BANDS set to 20 and keeps the default stride. This makes a full-frame invalidate only twenty bands. With 64 visible lines, four bands sit beyond the visible height, so the bench can check that a pass leaves them alone and that a later, taller pass still finds them dirty. The small band count also makes the end-of-pass clear cycle easy to hit exactly, which is how the bench checks the collision between a write and the clear.

// File: rtl/dirty_band_tracker.sv
module dirty_band_tracker #(
  parameter int NUM_BANDS   = 192,
  parameter int STRIDE_LOG2 = 10,
  parameter int PIX_AW      = 20,
  parameter int WIDTH_W     = 11,
  localparam int BAND_W     = $clog2(NUM_BANDS + 1),
  localparam int LINE_W     = BAND_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               true_color,
  input  logic [LINE_W-1:0]  vis_lines,
  input  logic [WIDTH_W-1:0] vis_width,
  input  logic               wr8_en,
  input  logic [PIX_AW-1:0]  wr8_addr,
  input  logic               wrw_en,
  input  logic [PIX_AW+1:0]  wrw_addr,
  input  logic               mark_all,
  input  logic               refresh_start,
  output logic               busy,
  output logic               rect_valid,
  output logic [LINE_W-1:0]  rect_y,
  output logic [LINE_W-1:0]  rect_h,
  output logic [WIDTH_W-1:0] rect_w
);

  localparam int SHIFT8 = STRIDE_LOG2 + 2;
  localparam int SHIFTW = STRIDE_LOG2 + 4;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_CLEAR} state_t;

  state_t               state;
  logic [NUM_BANDS-1:0] dirty8, dirtyw, set8, setw, clr_mask;
  logic [BAND_W-1:0]    scan_band, run_start, lo, hi, nbands_q, nb;
  logic                 run_open, any_dirty, tc_q, cur_dirty, clr_now;
  logic [31:0]          b8_idx, bw_idx, nb32;
  logic [BAND_W-1:0]    b8_sel, bw_sel;
  logic                 hit8, hitw;

  assign b8_idx = 32'(wr8_addr >> SHIFT8);
  assign bw_idx = 32'(wrw_addr >> SHIFTW);
  assign b8_sel = b8_idx[BAND_W-1:0];
  assign bw_sel = bw_idx[BAND_W-1:0];
  assign hit8   = wr8_en && (b8_idx < 32'(NUM_BANDS));
  assign hitw   = wrw_en && (bw_idx < 32'(NUM_BANDS));

  assign nb32 = (32'(vis_lines) + 32'd3) >> 2;
  assign nb   = (nb32 > 32'(NUM_BANDS)) ? BAND_W'(NUM_BANDS) : nb32[BAND_W-1:0];

  assign busy    = (state != S_IDLE);
  assign clr_now = (state == S_CLEAR) && any_dirty;

  always_comb begin
    set8 = '0;
    setw = '0;
    if (mark_all) begin
      set8 = '1;
      setw = '1;
    end else begin
      if (hit8) set8[b8_sel] = 1'b1;
      if (hitw) setw[bw_sel] = 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_BANDS; i++) begin : g_clr
    assign clr_mask[i] = clr_now && (BAND_W'(i) >= lo) && (BAND_W'(i) <= hi);
  end

  always_comb begin
    cur_dirty = 1'b0;
    if (scan_band < nbands_q)
      cur_dirty = dirty8[scan_band] | (tc_q & dirtyw[scan_band]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty8 <= '0;
      dirtyw <= '0;
    end else begin
      dirty8 <= (dirty8 & ~clr_mask) | set8;
      dirtyw <= (dirtyw & ~clr_mask) | setw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      scan_band  <= '0;
      run_start  <= '0;
      run_open   <= 1'b0;
      any_dirty  <= 1'b0;
      lo         <= '0;
      hi         <= '0;
      nbands_q   <= '0;
      tc_q       <= 1'b0;
      rect_valid <= 1'b0;
      rect_y     <= '0;
      rect_h     <= '0;
      rect_w     <= '0;
    end else begin
      rect_valid <= 1'b0;
      case (state)
        S_IDLE: if (refresh_start) begin
          scan_band <= '0;
          run_open  <= 1'b0;
          any_dirty <= 1'b0;
          nbands_q  <= nb;
          tc_q      <= true_color;
          rect_w    <= vis_width;
          state     <= S_SCAN;
        end
        S_SCAN: begin
          if (scan_band == nbands_q) begin
            if (run_open) begin
              rect_valid <= 1'b1;
              rect_y     <= {run_start, 2'b00};
              rect_h     <= {scan_band - run_start, 2'b00};
            end
            run_open <= 1'b0;
            state    <= S_CLEAR;
          end else begin
            if (cur_dirty) begin
              if (!run_open) begin
                run_start <= scan_band;
                run_open  <= 1'b1;
              end
              if (!any_dirty) lo <= scan_band;
              hi        <= scan_band;
              any_dirty <= 1'b1;
            end else if (run_open) begin
              rect_valid <= 1'b1;
              rect_y     <= {run_start, 2'b00};
              rect_h     <= {scan_band - run_start, 2'b00};
              run_open   <= 1'b0;
            end
            scan_band <= scan_band + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RECT_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> $past(state) == S_SCAN); // R2
  AST_RECT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> (rect_h != '0 && rect_h[1:0] == 2'b00 && rect_y[1:0] == 2'b00)); // R2
  AST_RECT_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> (32'(rect_y) + 32'(rect_h)) <= (32'(nbands_q) << 2)); // R3
  AST_CLEAR_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CLEAR |-> $past(state) == S_SCAN); // R4
  AST_MARK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    mark_all |=> (&dirty8 && &dirtyw)); // R6
  AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    hit8 |=> dirty8[$past(b8_sel)]); // R8

endmodule

// File: tb/tb_dirty_band_tracker.sv
module tb_dirty_band_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 20;
  localparam int BW  = $clog2(NB + 1);
  localparam int LW  = BW + 2;
  localparam int WW  = 11;
  localparam int PAW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic true_color = 1'b0;
  logic [LW-1:0] vis_lines = 7'd64;
  logic [WW-1:0] vis_width = 11'd640;
  logic wr8_en = 1'b0, wrw_en = 1'b0, mark_all = 1'b0, refresh_start = 1'b0;
  logic [PAW-1:0] wr8_addr = '0;
  logic [PAW+1:0] wrw_addr = '0;
  logic busy, rect_valid;
  logic [LW-1:0] rect_y, rect_h;
  logic [WW-1:0] rect_w;

  dirty_band_tracker #(.NUM_BANDS(NB), .PIX_AW(PAW), .WIDTH_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .true_color(true_color), .vis_lines(vis_lines),
    .vis_width(vis_width), .wr8_en(wr8_en), .wr8_addr(wr8_addr), .wrw_en(wrw_en),
    .wrw_addr(wrw_addr), .mark_all(mark_all), .refresh_start(refresh_start),
    .busy(busy), .rect_valid(rect_valid), .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w));

  always #(CLK_PERIOD/2) clk = ~clk;

  // [17] wide-plane writes, [16] true_color, [15:0] band mask over 16 visible bands
  localparam logic [17:0] VEC [8] = '{
    18'h0_0001, 18'h0_8000, 18'h0_0F0F, 18'h1_A5A5,
    18'h3_0330, 18'h2_00F0, 18'h0_FFFF, 18'h0_0000 };

  int n_chk = 0, n_fail = 0;
  int n_got = 0;
  int got_y [32], got_h [32], got_w [32];
  int exp_n;
  int exp_y [32], exp_h [32];

  always @(negedge clk) if (rect_valid && n_got < 32) begin
    got_y[n_got] = int'(rect_y);
    got_h[n_got] = int'(rect_h);
    got_w[n_got] = int'(rect_w);
    n_got++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic write8(input int band);
    @(negedge clk);
    wr8_en = 1'b1;
    wr8_addr = PAW'(band << 12);
    @(negedge clk);
    wr8_en = 1'b0;
  endtask

  task automatic writew(input int band, input int sub);
    @(negedge clk);
    wrw_en = 1'b1;
    wrw_addr = (PAW+2)'((band << 14) | (sub << 12));
    @(negedge clk);
    wrw_en = 1'b0;
  endtask

  task automatic do_pass();
    @(negedge clk);
    n_got = 0;
    refresh_start = 1'b1;
    @(negedge clk);
    refresh_start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic model(input logic [15:0] m, input int nbands);
    int s;
    exp_n = 0;
    s = -1;
    for (int b = 0; b <= nbands; b++) begin
      if (b < nbands && m[b]) begin
        if (s < 0) s = b;
      end else if (s >= 0) begin
        exp_y[exp_n] = 4 * s;
        exp_h[exp_n] = 4 * (b - s);
        exp_n++;
        s = -1;
      end
    end
  endtask

  task automatic compare(input string tag);
    check(n_got == exp_n, {tag, " rect count"}, n_got, exp_n);
    for (int k = 0; k < exp_n && k < n_got; k++) begin
      check(got_y[k] == exp_y[k], {tag, " rect_y"}, got_y[k], exp_y[k]);
      check(got_h[k] == exp_h[k], {tag, " rect_h"}, got_h[k], exp_h[k]);
      check(got_w[k] == int'(vis_width), "R9 rect_w", got_w[k], int'(vis_width));
    end
  endtask

  task automatic cleanup();
    vis_lines = 7'd80;
    true_color = 1'b1;
    @(negedge clk);
    mark_all = 1'b1;
    @(negedge clk);
    mark_all = 1'b0;
    do_pass();
    exp_n = 1; exp_y[0] = 0; exp_h[0] = 80;
    compare("R6 mark_all");
    vis_lines = 7'd64;
    true_color = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] eff;
    // R7: reset state
    write8(3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R7 busy after reset", int'(busy), 0);
    check(rect_valid == 1'b0, "R7 rect_valid after reset", int'(rect_valid), 0);
    write8(5);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_pass();
    exp_n = 0;
    compare("R7 reset clears dirty");

    // Vector table: R1 R2 R3 R5
    foreach (VEC[v]) begin
      true_color = VEC[v][16];
      for (int b = 0; b < 16; b++) if (VEC[v][b]) begin
        if (VEC[v][17]) writew(b, b % 4); else write8(b);
      end
      do_pass();
      eff = (VEC[v][17] && !VEC[v][16]) ? 16'h0 : VEC[v][15:0];
      model(eff, 16);
      compare(VEC[v][17] ? "R5 wide" : (VEC[v][15] ? "R3 open run" : "R1 R2 runs"));
      do_pass();
      exp_n = 0;
      compare("R4 cleared after pass");
      cleanup();
    end

    // R1: write beyond NUM_BANDS ignored, R4 and R9: bands beyond visible keep state
    write8(40);
    write8(18);
    write8(2);
    do_pass();
    exp_n = 1; exp_y[0] = 8; exp_h[0] = 4;
    compare("R9 visible only");
    vis_lines = 7'd80;
    do_pass();
    exp_n = 1; exp_y[0] = 72; exp_h[0] = 4;
    compare("R4 band outside span kept");
    do_pass();
    exp_n = 0;
    compare("R1 out of range ignored");

    // R9: visible height not a multiple of four
    vis_lines = 7'd10;
    vis_width = 11'd123;
    @(negedge clk);
    mark_all = 1'b1;
    @(negedge clk);
    mark_all = 1'b0;
    do_pass();
    exp_n = 1; exp_y[0] = 0; exp_h[0] = 12;
    compare("R9 partial band");
    vis_width = 11'd640;
    cleanup();

    // R8: write colliding with the end-of-pass clear
    vis_lines = 7'd8;
    write8(0);
    write8(1);
    @(negedge clk);
    n_got = 0;
    refresh_start = 1'b1;
    @(negedge clk);
    refresh_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R8 in clear cycle", int'(busy), 1);
    wr8_en = 1'b1;
    wr8_addr = '0;
    @(negedge clk);
    wr8_en = 1'b0;
    while (busy) @(negedge clk);
    exp_n = 1; exp_y[0] = 0; exp_h[0] = 8;
    compare("R8 first pass");
    do_pass();
    exp_n = 1; exp_y[0] = 0; exp_h[0] = 4;
    compare("R8 write survives clear");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule